// File: doc/BRIEF.md
# Sectioned Address Remap Range Splitter

This block sits in front of a cache range-maintenance sequencer. It accepts one maintenance request at a time: a start address, an exclusive end address and an operation code. It turns each request into zero, one or two range requests for the sequencer. Each emitted range carries cache-side addresses. A cache-side address is the CPU physical address plus an offset, and the offset depends on which address section the address lies in.

Addresses from 0x40000000 up to and including 0xBFFFFFFF form the middle section. A request that starts in the middle section and ends at or above 0xC0000000 would need two different offsets. Such a request is split at that boundary into two ranges, and each range is translated on its own. Clean and flush requests that cover at least the cache size collapse into a single whole-cache request. Requests that start below the middle section are rejected. Empty requests complete without issuing anything.

Requests enter on a valid/ready port and results leave on a second valid/ready port. After a request has been fully handled, a one-cycle completion pulse is raised.

Top module: `sect_remap_splitter`

## Requirements
- R1: A range address in 0x40000000..0xBFFFFFFF is emitted with 0x40000000 added.
- R2: Any other range address is emitted with 0x80000000 added, with the sum kept to 32 bits (it wraps modulo 2^32).
- R3: A request whose start is below 0x40000000 issues nothing and raises `err` for one cycle, in the cycle after acceptance. This check takes priority over every other rule, including the empty-range rule.
- R4: A valid-start request with end <= start issues nothing and raises `done` in the cycle after acceptance.
- R5: Op codes are 0 = invalidate, 1 = clean, 2 = flush and 3 = reserved, which is handled like invalidate. For op 1 or 2, when end - start >= CACHE_BYTES (default 0x80000), exactly one request is emitted with `out_whole`=1 and both address fields zero. Ops 0 and 3 never produce a whole-cache request.
- R6: When the end lies in the middle section, or the start lies outside it, exactly one translated range (start, end) is emitted.
- R7: Otherwise two ranges are emitted, in this order: first (translated start, translated 0xBFFFFFFF), then (translated 0xC0000000, translated end).
- R8: After reset the block is idle: `req_ready`=1 and `out_valid`=0, `done`=0, `err`=0. `req_ready` is low while any output is pending. An output held with `out_ready` low keeps all of its fields stable.
- R9: The second range is offered only after the first has been accepted. `done` pulses for one cycle in the cycle after the last output handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on valid and ready |
| req_start | input | 32 | CPU physical start address |
| req_end | input | 32 | CPU physical end address, exclusive |
| req_op | input | 2 | Operation code (see R5) |
| out_valid | output | 1 | Range request offered downstream |
| out_ready | input | 1 | Downstream accepts the range |
| out_start | output | 32 | Cache-side range start |
| out_end | output | 32 | Cache-side range end |
| out_op | output | 2 | Operation code of the request |
| out_whole | output | 1 | Whole-cache request, address fields zero |
| done | output | 1 | One-cycle pulse: request fully handled |
| err | output | 1 | One-cycle pulse: request rejected |

## Verification
A wrong section decision or offset appears in the address fields of the very first output, in the cycle after acceptance. A corrupted split state appears either as a missing second range or as a second range offered before the first was taken. Either fault is visible at the next handshake. Random starts spread over all three sections are mixed with lengths that cross 0xC0000000 and with lengths at the cache-size threshold. Directed cases pin down the exact boundary addresses, wrap-around and the error-before-empty priority.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_RSVD  = 2'd3
  } sr_op_e;

  typedef enum logic [1:0] {
    PLAN_ERR  = 2'd0,
    PLAN_NONE = 2'd1,
    PLAN_ONE  = 2'd2,
    PLAN_TWO  = 2'd3
  } sr_plan_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } sr_state_e;

  function automatic logic op_allows_whole(input logic [1:0] op);
    return (op == OP_CLEAN) || (op == OP_FLUSH);
  endfunction

endpackage

// File: rtl/sr_addr_xlat.sv
module sr_addr_xlat #(
  parameter int unsigned         ADDR_W  = 32,
  parameter logic [ADDR_W-1:0]   SEC_LO  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]   SEC_HI  = 32'hC000_0000,
  parameter logic [ADDR_W-1:0]   OFF_MID = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]   OFF_OUT = 32'h8000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_mid_o
);

  always_comb begin
    in_mid_o = (addr_i >= SEC_LO) && (addr_i < SEC_HI);
    addr_o   = addr_i + (in_mid_o ? OFF_MID : OFF_OUT);
  end

endmodule

// File: rtl/sr_range_plan.sv
module sr_range_plan
  import sr_pkg::*;
#(
  parameter int unsigned         ADDR_W      = 32,
  parameter logic [ADDR_W-1:0]   SEC_LO      = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]   SEC_HI      = 32'hC000_0000,
  parameter logic [ADDR_W-1:0]   OFF_MID     = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]   OFF_OUT     = 32'h8000_0000,
  parameter logic [ADDR_W-1:0]   CACHE_BYTES = 32'h0008_0000
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic [1:0]        op_i,
  output sr_plan_e          kind_o,
  output logic [ADDR_W-1:0] r0_start_o,
  output logic [ADDR_W-1:0] r0_end_o,
  output logic              r0_whole_o,
  output logic [ADDR_W-1:0] r1_start_o,
  output logic [ADDR_W-1:0] r1_end_o
);

  localparam int unsigned       NXL      = 2;
  localparam logic [ADDR_W-1:0] BND_LAST = SEC_HI - 1'b1;
  localparam logic [ADDR_W-1:0] BND_LO_X = BND_LAST + OFF_MID;
  localparam logic [ADDR_W-1:0] BND_HI_X = SEC_HI + OFF_OUT;

  logic [ADDR_W-1:0] xin  [NXL];
  logic [ADDR_W-1:0] xout [NXL];
  logic [NXL-1:0]    mid;
  logic [ADDR_W-1:0] span;

  assign xin[0] = start_i;
  assign xin[1] = end_i;

  for (genvar g = 0; g < NXL; g++) begin : g_xlat
    sr_addr_xlat #(
      .ADDR_W (ADDR_W),
      .SEC_LO (SEC_LO),
      .SEC_HI (SEC_HI),
      .OFF_MID(OFF_MID),
      .OFF_OUT(OFF_OUT)
    ) xlat_i (
      .addr_i  (xin[g]),
      .addr_o  (xout[g]),
      .in_mid_o(mid[g])
    );
  end

  assign span = end_i - start_i;

  always_comb begin
    kind_o     = PLAN_NONE;
    r0_start_o = '0;
    r0_end_o   = '0;
    r0_whole_o = 1'b0;
    r1_start_o = '0;
    r1_end_o   = '0;
    if (start_i < SEC_LO) begin
      kind_o = PLAN_ERR;
    end else if (end_i <= start_i) begin
      kind_o = PLAN_NONE;
    end else if (op_allows_whole(op_i) && (span >= CACHE_BYTES)) begin
      kind_o     = PLAN_ONE;
      r0_whole_o = 1'b1;
    end else if (mid[1] || !mid[0]) begin
      kind_o     = PLAN_ONE;
      r0_start_o = xout[0];
      r0_end_o   = xout[1];
    end else begin
      kind_o     = PLAN_TWO;
      r0_start_o = xout[0];
      r0_end_o   = BND_LO_X;
      r1_start_o = BND_HI_X;
      r1_end_o   = xout[1];
    end
  end

endmodule

// File: rtl/sr_issue_ctrl.sv
module sr_issue_ctrl
  import sr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  sr_plan_e          kind_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] r0_start_i,
  input  logic [ADDR_W-1:0] r0_end_i,
  input  logic              r0_whole_i,
  input  logic [ADDR_W-1:0] r1_start_i,
  input  logic [ADDR_W-1:0] r1_end_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_start,
  output logic [ADDR_W-1:0] out_end,
  output logic [OP_W-1:0]   out_op,
  output logic              out_whole,
  output logic              done,
  output logic              err
);

  sr_state_e         state_q, state_d;
  logic              two_q, two_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] s0_start_q, s0_end_q, s1_start_q, s1_end_q;
  logic              s0_whole_q;
  logic [OP_W-1:0]   op_q;
  logic              accept;
  logic              load_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign load_en   = accept && ((kind_i == PLAN_ONE) || (kind_i == PLAN_TWO));

  always_comb begin
    state_d = state_q;
    two_d   = two_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (kind_i)
            PLAN_ERR:  err_d  = 1'b1;
            PLAN_NONE: done_d = 1'b1;
            PLAN_ONE: begin
              state_d = ST_FIRST;
              two_d   = 1'b0;
            end
            PLAN_TWO: begin
              state_d = ST_FIRST;
              two_d   = 1'b1;
            end
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_FIRST: begin
        if (out_ready) begin
          if (two_q) begin
            state_d = ST_SECOND;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_SECOND: begin
        if (out_ready) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      two_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      two_q   <= two_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_start_q <= '0;
      s0_end_q   <= '0;
      s0_whole_q <= 1'b0;
      s1_start_q <= '0;
      s1_end_q   <= '0;
      op_q       <= '0;
    end else if (load_en) begin
      s0_start_q <= r0_start_i;
      s0_end_q   <= r0_end_i;
      s0_whole_q <= r0_whole_i;
      s1_start_q <= r1_start_i;
      s1_end_q   <= r1_end_i;
      op_q       <= op_i;
    end
  end

  always_comb begin
    out_valid = (state_q != ST_IDLE);
    out_op    = op_q;
    if (state_q == ST_SECOND) begin
      out_start = s1_start_q;
      out_end   = s1_end_q;
      out_whole = 1'b0;
    end else begin
      out_start = s0_start_q;
      out_end   = s0_end_q;
      out_whole = s0_whole_q && (state_q == ST_FIRST);
    end
  end

  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/sect_remap_splitter.sv
module sect_remap_splitter
  import sr_pkg::*;
#(
  parameter int unsigned         ADDR_W      = 32,
  parameter int unsigned         OP_W        = 2,
  parameter logic [ADDR_W-1:0]   SEC_LO      = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]   SEC_HI      = 32'hC000_0000,
  parameter logic [ADDR_W-1:0]   OFF_MID     = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]   OFF_OUT     = 32'h8000_0000,
  parameter logic [ADDR_W-1:0]   CACHE_BYTES = 32'h0008_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [OP_W-1:0]   req_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_start,
  output logic [ADDR_W-1:0] out_end,
  output logic [OP_W-1:0]   out_op,
  output logic              out_whole,
  output logic              done,
  output logic              err
);

  sr_plan_e          plan_kind;
  logic [ADDR_W-1:0] p0_start, p0_end, p1_start, p1_end;
  logic              p0_whole;

  sr_range_plan #(
    .ADDR_W     (ADDR_W),
    .SEC_LO     (SEC_LO),
    .SEC_HI     (SEC_HI),
    .OFF_MID    (OFF_MID),
    .OFF_OUT    (OFF_OUT),
    .CACHE_BYTES(CACHE_BYTES)
  ) plan_i (
    .start_i   (req_start),
    .end_i     (req_end),
    .op_i      (req_op),
    .kind_o    (plan_kind),
    .r0_start_o(p0_start),
    .r0_end_o  (p0_end),
    .r0_whole_o(p0_whole),
    .r1_start_o(p1_start),
    .r1_end_o  (p1_end)
  );

  sr_issue_ctrl #(
    .ADDR_W(ADDR_W),
    .OP_W  (OP_W)
  ) issue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .kind_i    (plan_kind),
    .op_i      (req_op),
    .r0_start_i(p0_start),
    .r0_end_i  (p0_end),
    .r0_whole_i(p0_whole),
    .r1_start_i(p1_start),
    .r1_end_i  (p1_end),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_start (out_start),
    .out_end   (out_end),
    .out_op    (out_op),
    .out_whole (out_whole),
    .done      (done),
    .err       (err)
  );

endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
  parameter int unsigned         ADDR_W = 32,
  parameter int unsigned         OP_W   = 2,
  parameter logic [ADDR_W-1:0]   SEC_LO = 32'h4000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_start,
  input logic [ADDR_W-1:0] req_end,
  input logic [OP_W-1:0]   req_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_start,
  input logic [ADDR_W-1:0] out_end,
  input logic [OP_W-1:0]   out_op,
  input logic              out_whole,
  input logic              done,
  input logic              err
);

  logic take;
  assign take = req_valid && req_ready;

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (req_start < SEC_LO)) |=> (err && !out_valid && !done)); // R3

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (req_start >= SEC_LO) && (req_end <= req_start)) |=> (done && !out_valid && !err)); // R4

  AST_WHOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_whole) |-> ((out_start == '0) && (out_end == '0))); // R5

  AST_WHOLE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_whole) |-> ((out_op == 2'd1) || (out_op == 2'd2))); // R5

  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_start) && $stable(out_end)
                                   && $stable(out_op) && $stable(out_whole))); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) || $past(take))); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !err)); // R9

endmodule

bind sect_remap_splitter sr_checker #(
  .ADDR_W(ADDR_W),
  .OP_W  (OP_W),
  .SEC_LO(SEC_LO)
) chk_i (.*);

// File: tb/sect_remap_splitter_tb_top.sv
`timescale 1ns/1ps
module sect_remap_splitter_tb_top;

  localparam logic [31:0] LO    = 32'h4000_0000;
  localparam logic [31:0] HI    = 32'hC000_0000;
  localparam logic [31:0] CSIZE = 32'h0008_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, out_valid, out_ready, out_whole, done, err;
  logic [31:0] req_start, req_end, out_start, out_end;
  logic [1:0]  req_op, out_op;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sect_remap_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .req_op(req_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
    .out_end(out_end), .out_op(out_op), .out_whole(out_whole),
    .done(done), .err(err)
  );

  function automatic logic is_mid(input logic [31:0] a);
    return (a >= LO) && (a < HI);
  endfunction

  function automatic logic [31:0] xl(input logic [31:0] a);
    return is_mid(a) ? a + 32'h4000_0000 : a + 32'h8000_0000;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] s, input logic [31:0] e,
                         input logic [1:0] op, input int bp);
    int          kind;
    int          n;
    logic [31:0] xs [2];
    logic [31:0] xe [2];
    logic        xw;
    string       tag;
    xs[0] = '0; xe[0] = '0; xs[1] = '0; xe[1] = '0; xw = 1'b0; n = 0;
    if (s < LO) kind = 0;
    else if (e <= s) kind = 1;
    else if ((op == 2'd1 || op == 2'd2) && (e - s >= CSIZE)) begin
      kind = 2; n = 1; xw = 1'b1;
    end else if (is_mid(e) || !is_mid(s)) begin
      kind = 3; n = 1; xs[0] = xl(s); xe[0] = xl(e);
    end else begin
      kind = 4; n = 2; xs[0] = xl(s); xe[0] = xl(HI - 1); xs[1] = xl(HI); xe[1] = xl(e);
    end
    while (!req_ready) @(negedge clk);
    req_start = s; req_end = e; req_op = op; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (kind == 0) begin
      check(err == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R3 reject",
            {err, out_valid, done}, 3'b100);
    end else if (kind == 1) begin
      check(done == 1'b1 && out_valid == 1'b0 && err == 1'b0, "R4 empty",
            {done, out_valid, err}, 3'b100);
    end else begin
      for (int i = 0; i < n; i++) begin
        if (kind == 2) tag = "R5 whole";
        else if (kind == 4) tag = (i == 0) ? "R7 first,R1" : "R7 second,R2";
        else tag = is_mid(s) ? "R1,R6 single" : "R2,R6 single";
        for (int k = 0; k < bp; k++) begin
          check(out_valid && !req_ready && out_start == xs[i] && out_end == xe[i],
                "R8 hold", {out_valid, req_ready, out_start, out_end},
                {1'b1, 1'b0, xs[i], xe[i]});
          @(negedge clk);
        end
        check(out_valid && out_start == xs[i] && out_end == xe[i] && out_whole == xw
              && out_op == op, tag, {out_valid, out_whole, out_op, out_start, out_end},
              {1'b1, xw, op, xs[i], xe[i]});
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        if (i + 1 < n)
          check(done == 1'b0 && out_valid == 1'b1, "R9 no early done",
                {done, out_valid}, 2'b01);
      end
      check(done == 1'b1 && out_valid == 1'b0, "R9 done", {done, out_valid}, 2'b10);
      @(negedge clk);
      check(done == 1'b0, "R9 pulse width", done, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
    req_start = '0; req_end = '0; req_op = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !out_valid && !done && !err, "R8 reset",
          {req_ready, out_valid, done, err}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    run_req(32'h3FFF_FFFF, 32'h3FFF_0000, 2'd0, 0);   // R3 priority over empty
    run_req(32'h0000_1000, 32'h0000_2000, 2'd1, 0);   // R3
    run_req(32'h5000_0000, 32'h5000_0000, 2'd2, 0);   // R4
    run_req(32'h4000_0000, 32'h4000_0020, 2'd0, 1);   // R1
    run_req(32'hF000_0000, 32'hF000_1000, 2'd1, 2);   // R2 wrap
    run_req(32'hBFFF_FFE0, 32'hC000_0040, 2'd2, 1);   // R7
    run_req(32'hBFFF_0000, 32'hC000_0000, 2'd0, 0);   // R7 end on boundary
    run_req(32'hBFF0_0000, 32'hC010_0000, 2'd1, 3);   // R5 whole clean
    run_req(32'h4000_0000, 32'h4008_0000, 2'd2, 0);   // R5 exactly cache size
    run_req(32'h4000_0000, 32'h4007_FFFF, 2'd2, 0);   // R6 just below size
    run_req(32'hBFF0_0000, 32'hC010_0000, 2'd0, 0);   // R5 invalidate never whole
    run_req(32'hBFF0_0000, 32'hC010_0000, 2'd3, 1);   // R5 reserved op
    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [31:0] s, e;
      int sel;
      sel = $urandom % 6;
      s = $urandom;
      case (sel)
        0: e = s + ($urandom % 32'h1000) + 1;
        1: e = s - ($urandom % 64);
        2: e = s + CSIZE + ($urandom % 32'h10_0000);
        3: begin s = HI - ($urandom % 32'h2000) - 1; e = HI + ($urandom % 32'h2000); end
        4: begin s = LO + ($urandom % 32'h8000_0000); e = s + ($urandom % 32'h4000) + 1; end
        default: begin s = HI + ($urandom % 32'h4000_0000); e = s + ($urandom % 32'h800) + 1; end
      endcase
      run_req(s, e, 2'($urandom % 4), int'($urandom % 3));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule